// File: doc/BRIEF.md
# Chained Descriptor DMA Channel

This block is one DMA channel that is steered entirely by control blocks held in system memory. Software writes the address of the first control block into the channel, then sets the run bit in the control/status word. The channel reads the six-word control block through its 32-bit memory master port. It then moves the requested number of 32-bit words from a source address to a destination address and follows the block's next pointer. It keeps doing this until it reaches a block whose next pointer is zero.

Each control block carries a transfer-info word. Flags in that word choose whether the source and destination addresses advance, and whether the source read or the destination write is skipped. They also choose whether the end of the block raises the interrupt output. A register slave port gives access to the control/status word and the control-block pointer. It also exposes read-only views of the block being worked on.

The memory master has no handshake. Every request is accepted in the cycle it is issued, and read data is valid in the following cycle.

Top module: `dma_chain_engine`

## Requirements
- R1: A control block is six 32-bit words read in the order +0, +4, +8, +12, +16, +20 from its start address. The words are transfer info, source address, destination address, byte length, stride and next-block pointer.
- R2: A control/status write with bit 0 set starts the channel only if the channel is not running, `chan_en` is high and the block pointer (offset 0x04) is nonzero. Otherwise bit 0 reads 0 and no memory request is issued.
- R3: After each block, the next-block pointer is copied into the block pointer at offset 0x04. A nonzero pointer is fetched next. A zero pointer clears control/status bit 0 and the channel goes idle.
- R4: Transfer-info bit 8 set makes the source address advance by 4 after each word, and bit 4 does the same for the destination address. When a bit is clear, that address stays fixed.
- R5: Transfer-info bit 11 set skips the source read, and the value written is zero.
- R6: Transfer-info bit 7 set skips the destination write. The source reads still take place.
- R7: Control/status bit 1 is set at the end of every block. If transfer-info bit 0 is set, bit 2 is set as well and `irq` goes high.
- R8: Writing 1 to control/status bit 1 clears it. Writing 1 to bit 2 clears it and drops `irq`. Writing 0 to either bit leaves it unchanged.
- R9: A control/status write stores only the value bits under mask 0x30FF0000 (bits 29:28 and 23:16), which read back as written. Bit 30 always reads 0.
- R10: Read-only views of the current block are at fixed offsets: 0x08 transfer info, 0x0C source, 0x10 destination, 0x14 remaining length, 0x18 stride and 0x1C next pointer. Any other offset reads 0.
- R11: The remaining length drops by 4 for each word moved. A block with length 0 completes after its fetch with no data access.
- R12: Writing control/status bit 31 stops the channel at once and issues no further memory requests. It clears bits 0, 1 and 2 and drops `irq`. Bit 31 reads 1 for exactly one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; must be high for a start to be accepted |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mem_req | output | 1 | Memory request, accepted in the same cycle |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after a read request |
| irq | output | 1 | Completion interrupt, high while control/status bit 2 is set |

## Verification
The main run uses a chain of four linked blocks. The first has both addresses advancing, which separates a true copy from repeated access to one word. The second has the read skipped and a fixed destination, which shows zero fill and a held address. The third has the write skipped and a fixed source, which shows reads still happen with nothing stored. The fourth has zero length, which shows a block can finish on its fetch alone.

A scoreboard compares every memory request with the expected sequence in order. This catches wrong fetch offsets, wrong word counts and out-of-order chaining. Separate single-block and two-block runs separate a plain end flag from an interrupt, and show that a reset request taken mid-transfer stops all memory traffic.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_FREQ,
      SQ_FWAIT,
      SQ_RREQ,
      SQ_RWAIT,
      SQ_WR,
      SQ_DONE
   } seq_state_e;

   // transfer-info flag positions
   localparam int TI_IRQ_EN   = 0;
   localparam int TI_DST_INC  = 4;
   localparam int TI_NO_WRITE = 7;
   localparam int TI_SRC_INC  = 8;
   localparam int TI_NO_READ  = 11;

   // control/status bit positions
   localparam int CS_RUN   = 0;
   localparam int CS_DONE  = 1;
   localparam int CS_IRQ   = 2;
   localparam int CS_RESET = 31;
   localparam logic [31:0] CS_KEEP_MASK = 32'h30FF_0000;

   // control-block word slots
   localparam int CB_TI     = 0;
   localparam int CB_SRC    = 1;
   localparam int CB_DST    = 2;
   localparam int CB_LEN    = 3;
   localparam int CB_STRIDE = 4;
   localparam int CB_NEXT   = 5;

   // register byte offsets
   localparam int OFS_CS     = 'h00;
   localparam int OFS_CBA    = 'h04;
   localparam int OFS_TI     = 'h08;
   localparam int OFS_SRC    = 'h0C;
   localparam int OFS_DST    = 'h10;
   localparam int OFS_LEN    = 'h14;
   localparam int OFS_STRIDE = 'h18;
   localparam int OFS_NEXT   = 'h1C;

endpackage

// File: rtl/dma_chain_csr.sv
module dma_chain_csr
   import dma_chain_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int REG_AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic              chan_en,
   input  logic              seq_busy,
   input  logic              blk_done,
   input  logic              blk_irq,
   input  logic              chain_stop,
   input  logic [ADDR_W-1:0] next_ptr,
   output logic [31:0]       cs_word,
   output logic [ADDR_W-1:0] cb_addr,
   output logic              start,
   output logic              flush,
   output logic              irq
);

   logic [31:0] keep_q;
   logic        run_q, end_q, int_q, rst_pend;
   logic        cs_wr, cba_wr;

   assign cs_wr  = wr_en && (int'(addr) == OFS_CS);
   assign cba_wr = wr_en && (int'(addr) == OFS_CBA);
   assign flush  = cs_wr && wdata[CS_RESET];
   assign start  = cs_wr && wdata[CS_RUN] && !wdata[CS_RESET] && !run_q
                   && chan_en && (cb_addr != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keep_q   <= '0;
         run_q    <= 1'b0;
         end_q    <= 1'b0;
         int_q    <= 1'b0;
         rst_pend <= 1'b0;
         cb_addr  <= '0;
      end else begin
         rst_pend <= flush;
         if (cs_wr) keep_q <= wdata & CS_KEEP_MASK;

         if (flush)           run_q <= 1'b0;
         else if (start)      run_q <= 1'b1;
         else if (chain_stop) run_q <= 1'b0;

         if (flush)                        end_q <= 1'b0;
         else if (blk_done)                end_q <= 1'b1;
         else if (cs_wr && wdata[CS_DONE]) end_q <= 1'b0;

         if (flush)                       int_q <= 1'b0;
         else if (blk_done && blk_irq)    int_q <= 1'b1;
         else if (cs_wr && wdata[CS_IRQ]) int_q <= 1'b0;

         if (blk_done)              cb_addr <= next_ptr;
         else if (cba_wr && !run_q) cb_addr <= wdata[ADDR_W-1:0];
      end
   end

   always_comb begin
      cs_word           = keep_q;
      cs_word[CS_RESET] = rst_pend;
      cs_word[CS_IRQ]   = int_q;
      cs_word[CS_DONE]  = end_q;
      cs_word[CS_RUN]   = run_q;
   end

   assign irq = int_q;

   a_r2_start_needs_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> ($past(cb_addr) != '0) && $past(chan_en));
   a_r3_run_tracks_seq: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !seq_busy);
   a_r3_stop_on_null: assert property (@(posedge clk) disable iff (!rst_n)
      chain_stop |-> (next_ptr == '0));
   a_r7_end_from_block: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(end_q) |-> $past(blk_done));
   a_r12_reset_idles: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !run_q && !irq && !end_q);

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
   import dma_chain_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int CB_WORDS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              flush,
   input  logic [ADDR_W-1:0] cb_base,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              busy,
   output logic              blk_done,
   output logic              blk_irq,
   output logic              chain_stop,
   output logic [ADDR_W-1:0] next_ptr,
   output logic [31:0]       view_ti,
   output logic [ADDR_W-1:0] view_src,
   output logic [ADDR_W-1:0] view_dst,
   output logic [31:0]       view_len,
   output logic [31:0]       view_stride
);

   localparam int IW   = $clog2(CB_WORDS);
   localparam int STEP = DATA_W / 8;

   seq_state_e        state;
   logic [IW-1:0]     idx;
   logic [ADDR_W-1:0] fetch_base, src_q, dst_q;
   logic [31:0]       len_q;
   logic [DATA_W-1:0] data_q;
   logic [31:0]       cb_word [CB_WORDS];
   logic [31:0]       ti;
   logic              last_fetch;

   assign ti         = cb_word[CB_TI];
   assign last_fetch = (int'(idx) == CB_WORDS - 1);

   for (genvar k = 0; k < CB_WORDS; k++) begin : g_cb_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                     cb_word[k] <= '0;
         else if (state == SQ_FWAIT && int'(idx) == k)   cb_word[k] <= mem_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= SQ_IDLE;
         idx        <= '0;
         fetch_base <= '0;
         src_q      <= '0;
         dst_q      <= '0;
         len_q      <= '0;
         data_q     <= '0;
      end else if (flush) begin
         state <= SQ_IDLE;
      end else begin
         unique case (state)
            SQ_IDLE: if (start) begin
               fetch_base <= cb_base;
               idx        <= '0;
               state      <= SQ_FREQ;
            end
            SQ_FREQ: state <= SQ_FWAIT;
            SQ_FWAIT: begin
               if (last_fetch) begin
                  src_q <= cb_word[CB_SRC][ADDR_W-1:0];
                  dst_q <= cb_word[CB_DST][ADDR_W-1:0];
                  len_q <= cb_word[CB_LEN];
                  state <= (cb_word[CB_LEN] == '0) ? SQ_DONE : SQ_RREQ;
               end else begin
                  idx   <= idx + 1'b1;
                  state <= SQ_FREQ;
               end
            end
            SQ_RREQ: begin
               if (ti[TI_NO_READ]) begin
                  data_q <= '0;
                  state  <= SQ_WR;
               end else begin
                  state  <= SQ_RWAIT;
               end
            end
            SQ_RWAIT: begin
               data_q <= mem_rdata;
               state  <= SQ_WR;
            end
            SQ_WR: begin
               if (ti[TI_SRC_INC]) src_q <= src_q + ADDR_W'(STEP);
               if (ti[TI_DST_INC]) dst_q <= dst_q + ADDR_W'(STEP);
               if (len_q <= 32'(STEP)) begin
                  len_q <= '0;
                  state <= SQ_DONE;
               end else begin
                  len_q <= len_q - 32'(STEP);
                  state <= SQ_RREQ;
               end
            end
            SQ_DONE: begin
               if (next_ptr != '0) begin
                  fetch_base <= next_ptr;
                  idx        <= '0;
                  state      <= SQ_FREQ;
               end else begin
                  state      <= SQ_IDLE;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state)
         SQ_FREQ: begin
            mem_req  = 1'b1;
            mem_addr = fetch_base + (ADDR_W'(idx) << 2);
         end
         SQ_RREQ: begin
            mem_req  = !ti[TI_NO_READ];
            mem_addr = src_q;
         end
         SQ_WR: begin
            mem_req   = !ti[TI_NO_WRITE];
            mem_we    = 1'b1;
            mem_addr  = dst_q;
            mem_wdata = data_q;
         end
         default: ;
      endcase
   end

   assign busy        = (state != SQ_IDLE);
   assign blk_done    = (state == SQ_DONE) && !flush;
   assign blk_irq     = ti[TI_IRQ_EN];
   assign next_ptr    = cb_word[CB_NEXT][ADDR_W-1:0];
   assign chain_stop  = blk_done && (next_ptr == '0);
   assign view_ti     = ti;
   assign view_src    = src_q;
   assign view_dst    = dst_q;
   assign view_len    = len_q;
   assign view_stride = cb_word[CB_STRIDE];

   a_r1_fetch_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_FREQ) |-> (int'(idx) < CB_WORDS));
   a_r4_src_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_WR && !ti[TI_SRC_INC]) |=> (src_q == $past(src_q)));
   a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && ti[TI_NO_READ]) |-> (mem_wdata == '0));
   a_r11_len_step: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_WR && !flush) |=> (len_q == '0) || (len_q == $past(len_q) - 32'(STEP)));

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
   import dma_chain_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int REG_AW   = 8,
   parameter int CB_WORDS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              irq
);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("dma_chain_engine: DATA_W must be 32");
   end
   if (ADDR_W != 32) begin : g_bad_addr_w
      $error("dma_chain_engine: ADDR_W must be 32");
   end
   if (REG_AW < 5) begin : g_bad_reg_aw
      $error("dma_chain_engine: REG_AW must cover offset 0x1C");
   end
   if (CB_WORDS != 6) begin : g_bad_cb_words
      $error("dma_chain_engine: control block layout needs CB_WORDS == 6");
   end

   logic [31:0]       cs_word, v_ti, v_len, v_stride;
   logic [ADDR_W-1:0] cb_addr, next_ptr, v_src, v_dst;
   logic              start, flush, busy, blk_done, blk_irq, chain_stop;

   dma_chain_csr #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr_en),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .chan_en    (chan_en),
      .seq_busy   (busy),
      .blk_done   (blk_done),
      .blk_irq    (blk_irq),
      .chain_stop (chain_stop),
      .next_ptr   (next_ptr),
      .cs_word    (cs_word),
      .cb_addr    (cb_addr),
      .start      (start),
      .flush      (flush),
      .irq        (irq)
   );

   dma_chain_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CB_WORDS(CB_WORDS)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .flush       (flush),
      .cb_base     (cb_addr),
      .mem_rdata   (mem_rdata),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .busy        (busy),
      .blk_done    (blk_done),
      .blk_irq     (blk_irq),
      .chain_stop  (chain_stop),
      .next_ptr    (next_ptr),
      .view_ti     (v_ti),
      .view_src    (v_src),
      .view_dst    (v_dst),
      .view_len    (v_len),
      .view_stride (v_stride)
   );

   always_comb begin
      case (int'(reg_addr))
         OFS_CS:     reg_rdata = cs_word;
         OFS_CBA:    reg_rdata = 32'(cb_addr);
         OFS_TI:     reg_rdata = v_ti;
         OFS_SRC:    reg_rdata = 32'(v_src);
         OFS_DST:    reg_rdata = 32'(v_dst);
         OFS_LEN:    reg_rdata = v_len;
         OFS_STRIDE: reg_rdata = v_stride;
         OFS_NEXT:   reg_rdata = 32'(next_ptr);
         default:    reg_rdata = '0;
      endcase
   end

   a_r6_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> cs_word[CS_RUN]);
   a_r7_irq_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(blk_done && blk_irq));

endmodule

// File: tb/dma_chain_engine_tb.sv
module dma_chain_engine_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_en = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        irq;

   always #4 clk = ~clk;   // 125 MHz

   dma_chain_engine u_dut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .irq(irq)
   );

   // memory model: accept every request, read data one cycle later
   logic [31:0] mem [1024];
   logic [31:0] rd_q = '0;
   assign mem_rdata = rd_q;
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
         else        rd_q <= mem[mem_addr[11:2]];
      end
   end

   int errors = 0;
   int checks = 0;
   int accesses = 0;

   typedef struct { bit we; logic [31:0] a; logic [31:0] d; } acc_t;
   acc_t exp_q[$];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && mem_req) begin
         accesses++;
         if (exp_q.size() == 0) begin
            chk("R2/R12 unexpected access", mem_addr, 32'hDEAD_DEAD);
         end else begin
            acc_t e;
            e = exp_q.pop_front();
            chk("R1/R3/R4 access kind", 32'(mem_we), 32'(e.we));
            chk("R1/R3/R4 access address", mem_addr, e.a);
            if (e.we) chk("R5 write data", mem_wdata, e.d);
         end
      end
   end

   // driver: walk the chain in the bench memory and queue the expected accesses
   task automatic push_chain(logic [31:0] base);
      while (base != 0) begin
         logic [31:0] ti, src, dst, len;
         for (int k = 0; k < 6; k++) exp_q.push_back('{1'b0, base + 32'(4*k), 32'h0});
         ti  = mem[base[11:2]];
         src = mem[base[11:2] + 1];
         dst = mem[base[11:2] + 2];
         len = mem[base[11:2] + 3];
         while (len != 0) begin
            if (!ti[11]) exp_q.push_back('{1'b0, src, 32'h0});
            if (!ti[7])  exp_q.push_back('{1'b1, dst, ti[11] ? 32'h0 : mem[src[11:2]]});
            if (ti[8]) src += 4;
            if (ti[4]) dst += 4;
            len = (len <= 4) ? 0 : len - 4;
         end
         base = mem[base[11:2] + 5];
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
      @(posedge clk);
      #1 reg_wr_en = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 2000; i++) begin
         rd(8'h00, v);
         if (!v[0]) break;
      end
   endtask

   task automatic put_cb(int base, logic [31:0] ti, logic [31:0] s, logic [31:0] d,
                         logic [31:0] l, logic [31:0] st, logic [31:0] nx);
      mem[(base>>2)+0] = ti; mem[(base>>2)+1] = s; mem[(base>>2)+2] = d;
      mem[(base>>2)+3] = l;  mem[(base>>2)+4] = st; mem[(base>>2)+5] = nx;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int base_acc;
      for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
      for (int i = 0; i < 32; i++)  mem[(32'h400>>2)+i] = 32'hC0DE_0000 | 32'(i * 16'h0101);
      for (int i = 0; i < 128; i++) mem[(32'h600>>2)+i] = 32'hFFFF_FFFF;
      put_cb('h100, 32'h0000_0111, 32'h400, 32'h600, 12, 32'h55, 32'h140);
      put_cb('h140, 32'h0000_0800, 32'h480, 32'h700, 8,  32'h0,  32'h180);
      put_cb('h180, 32'h0000_0090, 32'h420, 32'h780, 8,  32'h0,  32'h1C0);
      put_cb('h1C0, 32'h0000_0001, 32'h4A0, 32'h7A0, 0,  32'h77, 32'h0);
      put_cb('h240, 32'h0000_0110, 32'h440, 32'h640, 4,  32'h0,  32'h0);
      put_cb('h280, 32'h0000_0111, 32'h400, 32'h680, 4,  32'h0,  32'h2C0);
      put_cb('h2C0, 32'h0000_0110, 32'h400, 32'h6C0, 40, 32'h0,  32'h0);

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state
      rd(8'h00, v); chk("R2 reset CS", v, 32'h0);
      chk("R7 reset irq", 32'(irq), 32'h0);
      chk("R2 reset mem_req", 32'(mem_req), 32'h0);

      // R2: no start with enable low or null pointer
      wr(8'h04, 32'h100);
      wr(8'h00, 32'h1);
      rd(8'h00, v); chk("R2 enable low keeps idle", v & 32'h1, 32'h0);
      chan_en = 1'b1;
      wr(8'h04, 32'h0);
      wr(8'h00, 32'h1);
      rd(8'h00, v); chk("R2 null pointer keeps idle", v & 32'h1, 32'h0);
      repeat (10) @(posedge clk);
      chk("R2 no memory traffic", 32'(accesses), 32'h0);

      // main chain: R1 R3 R4 R5 R6 R11
      wr(8'h04, 32'h100);
      push_chain(32'h100);
      wr(8'h00, 32'h1);
      rd(8'h00, v); chk("R2 run bit set", v & 32'h1, 32'h1);
      wait_idle();
      chk("R1/R3 all queued accesses seen", 32'(exp_q.size()), 32'h0);
      rd(8'h00, v); chk("R3/R7 CS after chain", v, 32'h6);
      chk("R7 irq after int block", 32'(irq), 32'h1);
      rd(8'h04, v); chk("R3 pointer reaches zero", v, 32'h0);
      rd(8'h08, v); chk("R10 info view", v, 32'h1);
      rd(8'h0C, v); chk("R10 source view", v, 32'h4A0);
      rd(8'h10, v); chk("R10 dest view", v, 32'h7A0);
      rd(8'h14, v); chk("R11 zero length view", v, 32'h0);
      rd(8'h18, v); chk("R10 stride view", v, 32'h77);
      rd(8'h1C, v); chk("R10 next view", v, 32'h0);
      rd(8'h24, v); chk("R10 unmapped offset", v, 32'h0);
      chk("R4 copy word 0", mem[32'h600>>2], mem[32'h400>>2]);
      chk("R4 copy word 2", mem[(32'h600>>2)+2], mem[(32'h400>>2)+2]);
      chk("R11 no extra word", mem[(32'h600>>2)+3], 32'hFFFF_FFFF);
      chk("R5 zero fill", mem[32'h700>>2], 32'h0);
      chk("R4 fixed destination", mem[(32'h700>>2)+1], 32'hFFFF_FFFF);
      chk("R6 write skipped", mem[32'h780>>2], 32'hFFFF_FFFF);
      chk("R11 zero length no write", mem[32'h7A0>>2], 32'hFFFF_FFFF);

      // R8 write-one-to-clear
      wr(8'h00, 32'h2);
      rd(8'h00, v); chk("R8 end cleared, int kept", v, 32'h4);
      chk("R8 irq still high", 32'(irq), 32'h1);
      wr(8'h00, 32'h0);
      rd(8'h00, v); chk("R8 zero write no effect", v, 32'h4);
      wr(8'h00, 32'h4);
      rd(8'h00, v); chk("R8 int cleared", v, 32'h0);
      chk("R8 irq dropped", 32'(irq), 32'h0);

      // R7 block without interrupt enable
      wr(8'h04, 32'h240);
      push_chain(32'h240);
      wr(8'h00, 32'h1);
      wait_idle();
      rd(8'h00, v); chk("R7 end without int", v, 32'h2);
      chk("R7 irq stays low", 32'(irq), 32'h0);
      wr(8'h00, 32'h2);

      // R9 stored mask
      wr(8'h00, 32'h7FFF_FFF8);
      rd(8'h00, v); chk("R9 masked storage", v, 32'h30FF_0000);

      // R12 reset mid-transfer
      wr(8'h04, 32'h280);
      push_chain(32'h280);
      wr(8'h00, 32'h1);
      repeat (40) @(posedge clk);
      wr(8'h00, 32'h8000_0000);
      exp_q.delete();
      base_acc = accesses;
      rd(8'h00, v); chk("R12 reset pulse visible", v, 32'h8000_0000);
      chk("R12 irq dropped", 32'(irq), 32'h0);
      rd(8'h00, v); chk("R12 reset bit self clears", v, 32'h0);
      repeat (20) @(posedge clk);
      chk("R12 traffic stopped", 32'(accesses - base_acc), 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule